// File: doc/BRIEF.md
# Serial EEPROM Target with Page Buffer

This block is the bus-facing side of a small serial EEPROM. It sits on a two-wire I2C bus as a target and serves a 256-byte memory held in internal registers. SCL and SDA come in through two-flop synchronisers. START, repeated START and STOP are decoded by watching SDA change while SCL is high. The block drives SDA only by pulling it low through an open-drain enable.

A write transfer carries the device address, one word address and then data bytes. The data bytes go into a page-sized staging buffer. Their address advances inside the current 16-byte page and wraps to the start of that page. The staged bytes reach the memory when the STOP arrives. A fixed busy period follows, and during it the block does not answer its own address. A write-protect input decides, byte by byte, whether a received byte is staged.

Reads come in three forms. A read can start at the current address. A random read sets the address with a write that carries no data, then issues a repeated START. Any read becomes sequential while the controller keeps acknowledging; in that case the address runs over the whole array and wraps from the last byte to byte 0.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset the SDA enable is deasserted and every memory byte reads as 0x00.
- R2: A byte whose upper seven bits equal DEV_ADDR (bit 0 being read=1/write=0) is acknowledged by pulling SDA low in the ninth clock. Any other byte is not acknowledged, and the bytes that follow up to the next START have no effect on the memory.
- R3: In a write, the word address byte and every data byte are acknowledged, and the data bytes appear in the memory once the STOP has been seen.
- R4: During a write the address advances only in its low four bits, so bytes written past the end of a 16-byte page land at the start of the same page.
- R5: From a STOP that commits data until WR_CYCLES clock cycles later, the device address is not acknowledged. After that it is acknowledged again.
- R6: A data byte received while the write-protect input is high is still acknowledged but is not stored.
- R7: A random read returns the byte at the word address given in the preceding dummy write. The dummy write is a device address with write, then the word address, then a repeated START and the device address with read.
- R8: A read that begins without a word address returns the byte at the address one past the last byte accessed.
- R9: While the controller acknowledges read bytes, the block keeps sending bytes from successive addresses, and it wraps from address 0xFF to 0x00.
- R10: After a read byte is answered with no acknowledge, the block releases SDA. After the following STOP it waits for a new START.
- R11: The SDA enable is only ever asserted while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | When high, pulls the data line low |
| wp_i | input | 1 | Write protect, high blocks storing of data bytes |

## Verification
The hardest cases to reach are the ones that depend on where the address counter sits when the bus arrives. One is the page wrap, where a write must begin near the end of a page and run past it. The other is the array wrap, where a sequential read has to cross from 0xFF to 0x00 with known data on both sides. The bench reaches both with single-byte writes that place marker values at 0xFF and 0x00, and with a five-byte write that starts at offset 14 of a page. It then reads both regions back. For the busy window, the bench puts a device address on the bus right after the committing STOP.

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
  parameter logic [6:0] DEV_ADDR   = 7'h50,
  parameter int         WR_CYCLES  = 2000,
  parameter int         MEM_BYTES  = 256,
  parameter int         PAGE_BYTES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  input  logic wp_i
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int TW = $clog2(WR_CYCLES + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DEV_ACK, S_WA, S_WA_ACK, S_WD, S_WD_ACK, S_RD, S_RD_ACK
  } st_t;

  st_t st;
  logic [2:0] scl_r, sda_r;
  logic [1:0] wp_r;
  logic [3:0] cnt;
  logic [7:0] sh, tx;
  logic [AW-1:0] addr;
  logic rw, mack;
  logic [TW-1:0] wr_tmr;
  logic [7:0] mem [MEM_BYTES];
  logic [7:0] pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pend;

  wire scl_rise = scl_r[1] & ~scl_r[2];
  wire scl_fall = ~scl_r[1] & scl_r[2];
  wire start_det = scl_r[1] & scl_r[2] & sda_r[2] & ~sda_r[1];
  wire stop_det  = scl_r[1] & scl_r[2] & ~sda_r[2] & sda_r[1];
  wire rx_state  = (st == S_DEV) || (st == S_WA) || (st == S_WD);
  wire [7:0] rd_byte = mem[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_r <= '1;
      sda_r <= '1;
      wp_r  <= '0;
    end else begin
      scl_r <= {scl_r[1:0], scl_i};
      sda_r <= {sda_r[1:0], sda_i};
      wp_r  <= {wp_r[0], wp_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      sh     <= '0;
      tx     <= '0;
      addr   <= '0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
      wr_tmr <= '0;
      pend   <= '0;
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= '0;
    end else begin
      if (wr_tmr != '0) wr_tmr <= wr_tmr - 1'b1;
      if (stop_det) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
        if (|pend) begin
          for (int i = 0; i < PAGE_BYTES; i++)
            if (pend[i]) mem[{addr[AW-1:PW], PW'(i)}] <= pbuf[i];
          wr_tmr <= TW'(WR_CYCLES);
        end
        pend <= '0;
      end else if (start_det) begin
        st     <= S_DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
        pend   <= '0;
      end else begin
        if (rx_state && scl_rise) begin
          sh  <= {sh[6:0], sda_r[1]};
          cnt <= cnt + 1'b1;
        end else if (rx_state && scl_fall && cnt == 4'd8) begin
          cnt <= '0;
          if (st == S_DEV) begin
            if (sh[7:1] == DEV_ADDR && wr_tmr == '0) begin
              st     <= S_DEV_ACK;
              sda_oe <= 1'b1;
              rw     <= sh[0];
            end else begin
              st <= S_IDLE;
            end
          end else if (st == S_WA) begin
            addr   <= sh[AW-1:0];
            sda_oe <= 1'b1;
            st     <= S_WA_ACK;
          end else begin
            if (!wp_r[1]) begin
              pbuf[addr[PW-1:0]] <= sh;
              pend[addr[PW-1:0]] <= 1'b1;
            end
            addr[PW-1:0] <= addr[PW-1:0] + 1'b1;
            sda_oe       <= 1'b1;
            st           <= S_WD_ACK;
          end
        end

        case (st)
          S_DEV_ACK:
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                st     <= S_RD;
                tx     <= rd_byte;
                sda_oe <= ~rd_byte[7];
              end else begin
                st     <= S_WA;
                sda_oe <= 1'b0;
              end
            end
          S_WA_ACK, S_WD_ACK:
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              st     <= S_WD;
            end
          S_RD:
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                sda_oe <= 1'b0;
                addr   <= addr + 1'b1;
                st     <= S_RD_ACK;
              end else begin
                cnt    <= cnt + 1'b1;
                tx     <= {tx[6:0], 1'b0};
                sda_oe <= ~tx[6];
              end
            end
          S_RD_ACK:
            if (scl_rise) begin
              mack <= ~sda_r[1];
            end else if (scl_fall) begin
              if (mack) begin
                st     <= S_RD;
                cnt    <= '0;
                tx     <= rd_byte;
                sda_oe <= ~rd_byte[7];
              end else begin
                st <= S_IDLE;
              end
            end
          default: ;
        endcase
      end
    end
  end

  // R11
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_r[1]);

  // R2
  oe_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (st == S_DEV_ACK || st == S_WA_ACK || st == S_WD_ACK || st == S_RD));

  // R5
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DEV_ACK && $past(st) == S_DEV) |-> $past(wr_tmr) == '0);

  // R5
  wr_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tmr != '0) |=> (wr_tmr == $past(wr_tmr) - 1'b1));

  // R4
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WD_ACK && $past(st) == S_WD) |-> addr[AW-1:PW] == $past(addr[AW-1:PW]));

  // R9
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD_ACK && $past(st) == S_RD) |-> addr == AW'($past(addr) + 1'b1));

endmodule

// File: tb/sim_i2c_eeprom_target.sv
module sim_i2c_eeprom_target;
  localparam int WR = 2000;
  localparam int T  = 25;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  i2c_eeprom_target #(.DEV_ADDR(DEV), .WR_CYCLES(WR)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .wp_i(wp)
  );

  int checks = 0;
  int fails = 0;
  logic [7:0] model [256];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] got_q [$];
  event got_ev;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial forever begin
    @(got_ev);
    while (got_q.size() > 0) begin
      logic [7:0] g, e;
      string t;
      g = got_q.pop_front();
      if (exp_q.size() == 0) begin
        chk(1'b0, "unexpected read byte", int'(g), 0);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(g == e, t, int'(g), int'(e));
      end
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(T);
    scl_m = 1'b1; hold(T);
    sda_m = 1'b0; hold(T);
    scl_m = 1'b0; hold(3);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(T);
    scl_m = 1'b1; hold(T);
    sda_m = 1'b1; hold(T);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hold(T);
      scl_m = 1'b1; hold(T);
      scl_m = 1'b0; hold(3);
    end
    sda_m = 1'b1; hold(T);
    scl_m = 1'b1; hold(T / 2);
    acked = !sda_line;
    hold(T / 2);
    scl_m = 1'b0; hold(3);
  endtask

  task automatic recv_byte(input bit ack);
    logic [7:0] b;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(T);
      scl_m = 1'b1; hold(T / 2);
      b[i] = sda_line;
      hold(T / 2);
      scl_m = 1'b0; hold(3);
    end
    sda_m = ack ? 1'b0 : 1'b1; hold(T);
    scl_m = 1'b1; hold(T);
    scl_m = 1'b0; hold(3);
    sda_m = 1'b1;
    got_q.push_back(b);
    ->got_ev;
  endtask

  task automatic expect_byte(input logic [7:0] v, input string req);
    exp_q.push_back(v);
    tag_q.push_back(req);
  endtask

  task automatic write_seq(input logic [7:0] a, input int n, input logic [7:0] first,
                           input bit settle);
    bit ak;
    logic [7:0] p;
    p = a;
    bus_start();
    send_byte({DEV, 1'b0}, ak);
    chk(ak, "R2 device address ack", int'(ak), 1);
    send_byte(a, ak);
    chk(ak, "R3 word address ack", int'(ak), 1);
    for (int i = 0; i < n; i++) begin
      send_byte(first + 8'(i), ak);
      chk(ak, "R3 data byte ack", int'(ak), 1);
      if (!wp) model[p] = first + 8'(i);
      p = {p[7:4], p[3:0] + 4'd1};
    end
    bus_stop();
    if (settle) hold(WR + 100);
  endtask

  task automatic read_random(input logic [7:0] a, input int n, input string req);
    bit ak;
    bus_start();
    send_byte({DEV, 1'b0}, ak);
    chk(ak, "R7 dummy write ack", int'(ak), 1);
    send_byte(a, ak);
    chk(ak, "R7 word address ack", int'(ak), 1);
    bus_start();
    send_byte({DEV, 1'b1}, ak);
    chk(ak, "R7 read address ack", int'(ak), 1);
    for (int i = 0; i < n; i++) begin
      expect_byte(model[8'(a + 8'(i))], req);
      recv_byte(i != n - 1);
    end
    chk(sda_oe == 1'b0, "R10 released after no-ack", int'(sda_oe), 0);
    bus_stop();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    hold(5);
    rst_n = 1'b1;
    hold(5);
    chk(sda_oe == 1'b0, "R1 sda released at reset", int'(sda_oe), 0);

    read_random(8'h10, 2, "R1 memory clear");

    begin : busy_case
      bit ak;
      write_seq(8'h10, 5, 8'hA0, 1'b0);
      bus_start();
      send_byte({DEV, 1'b1}, ak);
      chk(!ak, "R5 no ack while busy", int'(ak), 0);
      bus_stop();
      hold(WR + 100);
    end

    read_random(8'h10, 2, "R7 random read");

    begin : current_case
      bit ak;
      bus_start();
      send_byte({DEV, 1'b1}, ak);
      chk(ak, "R5 ack after busy", int'(ak), 1);
      expect_byte(model[8'h12], "R8 current address read");
      recv_byte(1'b0);
      bus_stop();
    end

    read_random(8'h10, 5, "R9 sequential read");

    write_seq(8'h2E, 5, 8'h50, 1'b1);
    read_random(8'h2E, 2, "R4 page end bytes");
    read_random(8'h20, 3, "R4 wrapped bytes");
    read_random(8'h30, 1, "R4 next page untouched");

    wp = 1'b1;
    write_seq(8'h40, 2, 8'h77, 1'b1);
    wp = 1'b0;
    hold(10);
    read_random(8'h40, 2, "R6 protected bytes not stored");

    begin : mismatch_case
      bit ak;
      bus_start();
      send_byte({7'h51, 1'b0}, ak);
      chk(!ak, "R2 foreign address no ack", int'(ak), 0);
      send_byte(8'h60, ak);
      send_byte(8'h12, ak);
      bus_stop();
      hold(WR + 100);
    end
    read_random(8'h60, 1, "R2 foreign transfer ignored");

    write_seq(8'hFF, 1, 8'h99, 1'b1);
    write_seq(8'h00, 1, 8'h11, 1'b1);
    read_random(8'hFE, 3, "R9 wrap at end of array");

    hold(20);
    chk(exp_q.size() == 0, "R10 all read bytes observed", exp_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule